// File: doc/BRIEF.md
# Streaming 3x3 Peak Filter with Threshold

This block takes a raster-ordered stream of signed strength values, one per pixel, and returns a binary map with one 8-bit result per pixel. For each position it looks at the 3x3 patch around the pixel. A pixel survives only if none of its eight neighbours holds a strictly larger value. A survivor is then marked 255 if it is strictly above a compile-time threshold, and 0 otherwise. Neighbours that fall outside the image count as zero.

The frame size is given at run time on two inputs and is captured with the start-of-frame sample. Storage is two line buffers indexed by column plus a 3x3 tap window. Each result leaves the block once the sample to the lower right of its centre has arrived. After the end-of-frame sample the block produces the remaining results on its own, one per cycle.

Top module: `corner_peak_filter`

## Requirements
- R1: A synchronous active-high `rst` clears the line buffers, the position counters and the output registers. While reset is held and in the first cycle after it, `outValid`, `outSof` and `outEof` are 0 and `outMap` is 8'h00.
- R2: A frame opens when `inValid` and `inSof` are both high while no frame is open. On that sample, `rowCount` and `colCount` (each from 2 up to its maximum) are captured. A valid sample that arrives while no frame is open and without `inSof` is ignored.
- R3: Each frame yields exactly rows*cols results in raster order, each flagged by `outValid`. `outSof` is high with the first result only and `outEof` with the last result only.
- R4: The neighbourhood is the 3x3 patch centred on the pixel. A neighbour outside the image reads as zero. The patch never reaches from the end of one row into the start of the next, or the reverse.
- R5: A centre is suppressed when any neighbour is strictly greater than it. A neighbour equal to the centre does not suppress it.
- R6: A surviving centre gives `outMap` = 8'hFF when it is strictly greater than `THRESH` (default 2000), and 8'h00 otherwise. A value equal to `THRESH` gives 8'h00.
- R7: With an unbroken input stream, the result for raster position m appears in the cycle after the sample at raster position m+cols+1 is accepted.
- R8: After the sample flagged `inEof` is accepted, the remaining cols+1 results come out one per cycle with no further input. The last result appears cols+1 cycles after the end sample. Any input presented while this flush runs is ignored.
- R9: Cycles with `inValid` low between samples pause the block and do not change any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rowCount | input | ROW_W (10) | Image height, captured at frame start |
| colCount | input | COL_W (7) | Image width, captured at frame start |
| inValid | input | 1 | Input sample valid |
| inSof | input | 1 | Marks the first sample of a frame |
| inEof | input | 1 | Marks the last sample of a frame |
| inData | input | DW (16) | Signed strength value |
| outValid | output | 1 | Result valid |
| outSof | output | 1 | First result of the frame |
| outEof | output | 1 | Last result of the frame |
| outMap | output | 8 | 8'hFF for a kept peak above threshold, else 8'h00 |

## Verification
The hardest situations to reach from the ports are the row-boundary cases. In a flat delay line, the last pixel of one row and the first pixel of the next sit side by side, so a large value at a row end would wrongly suppress or survive next to a row start if the edge masks failed. The table frame puts strong values at exactly those raster neighbours, so any leak across the boundary changes the map.

The flush tail is also hard to reach. The bench presents fresh valid samples, including a start flag, during the cycles in which the block empties itself. It then checks that the count, order and timing of the results stay unchanged, with widths down to two columns and up to the full line-buffer depth.

// File: rtl/corner_peak_pkg.sv
package corner_peak_pkg;

  // Strobes and edge qualifiers handed from control to datapath.
  typedef struct packed {
    logic step;     // advance the delay line by one sample
    logic flush;    // the current step carries no real input sample
    logic emit;     // a result is due on this step
    logic topOk;    // row above the centre lies inside the image
    logic botOk;    // row below the centre lies inside the image
    logic leftOk;   // column left of the centre lies inside the image
    logic rightOk;  // column right of the centre lies inside the image
    logic first;    // the centre is the first pixel of the frame
    logic last;     // the centre is the last pixel of the frame
  } peakCtl_t;

  localparam int WIN_TAPS   = 9;
  localparam int CENTRE_TAP = 4;
  localparam logic [7:0] MAP_HIT  = 8'hFF;
  localparam logic [7:0] MAP_MISS = 8'h00;

endpackage

// File: rtl/peak_line_buf.sv
module peak_line_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wrEn,
  input  logic [AW-1:0]        addr,
  input  logic signed [DW-1:0] wrData,
  output logic signed [DW-1:0] rdData
);

  logic signed [DW-1:0] mem [DEPTH];

  // Read-before-write: rdData shows the value stored one row ago.
  assign rdData = mem[addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wrEn) begin
      mem[addr] <= wrData;
    end
  end

endmodule

// File: rtl/peak_ctrl.sv
module peak_ctrl
  import corner_peak_pkg::*;
#(
  parameter int MAX_ROWS = 1023,
  parameter int MAX_COLS = 64,
  localparam int ROW_W   = $clog2(MAX_ROWS + 1),
  localparam int COL_W   = $clog2(MAX_COLS + 1),
  localparam int AW      = $clog2(MAX_COLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             inEof,
  input  logic [ROW_W-1:0] rowsIn,
  input  logic [COL_W-1:0] colsIn,
  output peakCtl_t         ctl,
  output logic [AW-1:0]    lbAddr
);

  logic             active;
  logic             inputDone;
  logic [ROW_W-1:0] rowsQ;
  logic [COL_W-1:0] colsQ;
  logic [COL_W:0]   kCnt;
  logic [ROW_W-1:0] cRow;
  logic [COL_W-1:0] cCol;
  logic [AW-1:0]    ptrQ;

  logic             sofTake, dataTake, flushTake, stepNow, emitNow;
  logic [COL_W-1:0] curCols;
  logic [AW-1:0]    curPtr;
  logic [COL_W:0]   primeTarget;
  logic             atLastCol, atLastRow;

  assign sofTake   = inValid && inSof && !active;
  assign dataTake  = inValid && active && !inputDone;
  assign flushTake = active && inputDone;
  assign stepNow   = sofTake || dataTake || flushTake;

  assign curCols     = sofTake ? colsIn : colsQ;
  assign curPtr      = sofTake ? '0 : ptrQ;
  assign primeTarget = {1'b0, colsQ} + (COL_W+1)'(1);
  assign emitNow     = (dataTake || flushTake) && (kCnt == primeTarget);

  assign atLastCol = (cCol == colsQ - COL_W'(1));
  assign atLastRow = (cRow == rowsQ - ROW_W'(1));

  always_comb begin
    ctl         = '0;
    ctl.step    = stepNow;
    ctl.flush   = flushTake;
    ctl.emit    = emitNow;
    ctl.topOk   = (cRow != '0);
    ctl.botOk   = !atLastRow;
    ctl.leftOk  = (cCol != '0);
    ctl.rightOk = !atLastCol;
    ctl.first   = (cRow == '0) && (cCol == '0);
    ctl.last    = atLastRow && atLastCol;
  end

  assign lbAddr = curPtr;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      inputDone <= 1'b0;
      rowsQ     <= '0;
      colsQ     <= '0;
      kCnt      <= '0;
      cRow      <= '0;
      cCol      <= '0;
      ptrQ      <= '0;
    end else if (stepNow) begin
      ptrQ <= (COL_W'(curPtr) == curCols - COL_W'(1)) ? '0 : curPtr + AW'(1);
      if (sofTake) begin
        active    <= 1'b1;
        inputDone <= inEof;
        rowsQ     <= rowsIn;
        colsQ     <= colsIn;
        kCnt      <= (COL_W+1)'(1);
        cRow      <= '0;
        cCol      <= '0;
      end else begin
        if (kCnt != primeTarget) kCnt <= kCnt + (COL_W+1)'(1);
        if (dataTake && inEof) inputDone <= 1'b1;
        if (emitNow) begin
          if (atLastRow && atLastCol) begin
            active    <= 1'b0;
            inputDone <= 1'b0;
          end else if (atLastCol) begin
            cCol <= '0;
            cRow <= cRow + ROW_W'(1);
          end else begin
            cCol <= cCol + COL_W'(1);
          end
        end
      end
    end
  end

  // R3: the centre position stays inside the captured frame.
  p_coords_in_range_r3: assert property (@(posedge clk) disable iff (rst)
    active |-> (cRow < rowsQ) && (cCol < colsQ));

  // R7: the line-buffer pointer wraps at the captured width.
  p_ptr_in_range_r7: assert property (@(posedge clk) disable iff (rst)
    active |-> (COL_W'(ptrQ) < colsQ));

  // R8: the last result closes the frame.
  p_last_closes_frame_r8: assert property (@(posedge clk) disable iff (rst)
    (emitNow && atLastRow && atLastCol) |=> !active);

endmodule

// File: rtl/peak_datapath.sv
module peak_datapath
  import corner_peak_pkg::*;
#(
  parameter int DW       = 16,
  parameter int MAX_COLS = 64,
  parameter int THRESH   = 2000,
  localparam int AW      = $clog2(MAX_COLS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  peakCtl_t             ctl,
  input  logic [AW-1:0]        lbAddr,
  input  logic signed [DW-1:0] inData,
  output logic                 outValid,
  output logic                 outSof,
  output logic                 outEof,
  output logic [7:0]           outMap
);

  localparam logic signed [DW-1:0] THRESH_V = DW'(THRESH);
  localparam logic signed [DW-1:0] ZERO_V   = '0;

  logic signed [DW-1:0] newest;
  logic signed [DW-1:0] lbIn  [2];
  logic signed [DW-1:0] lbOut [2];
  logic signed [DW-1:0] bot1, bot2, mid1, mid2, top1, top2;
  logic signed [DW-1:0] win [WIN_TAPS];
  logic [WIN_TAPS-1:0]  okMask;
  logic [WIN_TAPS-1:0]  beats;
  logic                 suppressed, hit;

  assign newest  = ctl.flush ? ZERO_V : inData;
  assign lbIn[0] = newest;
  assign lbIn[1] = lbOut[0];

  // Two chained row delays: row below -> centre row -> row above.
  for (genvar g = 0; g < 2; g++) begin : gLine
    peak_line_buf #(.DW(DW), .DEPTH(MAX_COLS)) uLine (
      .clk    (clk),
      .rst    (rst),
      .wrEn   (ctl.step),
      .addr   (lbAddr),
      .wrData (lbIn[g]),
      .rdData (lbOut[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bot1 <= '0; bot2 <= '0;
      mid1 <= '0; mid2 <= '0;
      top1 <= '0; top2 <= '0;
    end else if (ctl.step) begin
      bot1 <= newest;   bot2 <= bot1;
      mid1 <= lbOut[0]; mid2 <= mid1;
      top1 <= lbOut[1]; top2 <= top1;
    end
  end

  // Taps in raster order: 0..2 above, 3..5 centre row, 6..8 below.
  assign win[0] = top2;     assign win[1] = top1; assign win[2] = lbOut[1];
  assign win[3] = mid2;     assign win[4] = mid1; assign win[5] = lbOut[0];
  assign win[6] = bot2;     assign win[7] = bot1; assign win[8] = newest;

  assign okMask[0] = ctl.topOk && ctl.leftOk;
  assign okMask[1] = ctl.topOk;
  assign okMask[2] = ctl.topOk && ctl.rightOk;
  assign okMask[3] = ctl.leftOk;
  assign okMask[4] = 1'b1;
  assign okMask[5] = ctl.rightOk;
  assign okMask[6] = ctl.botOk && ctl.leftOk;
  assign okMask[7] = ctl.botOk;
  assign okMask[8] = ctl.botOk && ctl.rightOk;

  for (genvar i = 0; i < WIN_TAPS; i++) begin : gCmp
    if (i == CENTRE_TAP) begin : gSelf
      assign beats[i] = 1'b0;
    end else begin : gNb
      assign beats[i] = (okMask[i] ? win[i] : ZERO_V) > win[CENTRE_TAP];
    end
  end

  assign suppressed = |beats;
  assign hit        = !suppressed && (win[CENTRE_TAP] > THRESH_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outSof   <= 1'b0;
      outEof   <= 1'b0;
      outMap   <= MAP_MISS;
    end else begin
      outValid <= ctl.emit;
      outSof   <= ctl.emit && ctl.first;
      outEof   <= ctl.emit && ctl.last;
      outMap   <= (ctl.emit && hit) ? MAP_HIT : MAP_MISS;
    end
  end

  // R7: a result is only due on a step of the delay line.
  p_emit_is_step_r7: assert property (@(posedge clk) disable iff (rst)
    ctl.emit |-> ctl.step);

  // R1: outputs are quiet in the first cycle after reset.
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !outValid && (outMap == MAP_MISS));

  // R3: frame flags only travel with a valid result.
  p_flags_need_valid_r3: assert property (@(posedge clk) disable iff (rst)
    (outSof || outEof) |-> outValid);

  // R3: a frame end is never flagged on two cycles in a row.
  p_eof_single_r3: assert property (@(posedge clk) disable iff (rst)
    outEof |=> !outEof);

endmodule

// File: rtl/corner_peak_filter.sv
module corner_peak_filter
  import corner_peak_pkg::*;
#(
  parameter int DW       = 16,
  parameter int MAX_ROWS = 1023,
  parameter int MAX_COLS = 64,
  parameter int THRESH   = 2000,
  localparam int ROW_W   = $clog2(MAX_ROWS + 1),
  localparam int COL_W   = $clog2(MAX_COLS + 1),
  localparam int AW      = $clog2(MAX_COLS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ROW_W-1:0]     rowCount,
  input  logic [COL_W-1:0]     colCount,
  input  logic                 inValid,
  input  logic                 inSof,
  input  logic                 inEof,
  input  logic signed [DW-1:0] inData,
  output logic                 outValid,
  output logic                 outSof,
  output logic                 outEof,
  output logic [7:0]           outMap
);

  peakCtl_t      ctl;
  logic [AW-1:0] lbAddr;

  peak_ctrl #(.MAX_ROWS(MAX_ROWS), .MAX_COLS(MAX_COLS)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inSof   (inSof),
    .inEof   (inEof),
    .rowsIn  (rowCount),
    .colsIn  (colCount),
    .ctl     (ctl),
    .lbAddr  (lbAddr)
  );

  peak_datapath #(.DW(DW), .MAX_COLS(MAX_COLS), .THRESH(THRESH)) uDp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .lbAddr   (lbAddr),
    .inData   (inData),
    .outValid (outValid),
    .outSof   (outSof),
    .outEof   (outEof),
    .outMap   (outMap)
  );

endmodule

// File: tb/test_corner_peak_filter.sv
`timescale 1ns/1ps
module test_corner_peak_filter;

  localparam int THR = 2000;
  localparam int RA  = 4;
  localparam int CA  = 6;
  // Table frame, raster order, 4 rows x 6 columns.
  localparam int FRAME_A [24] = '{
      -50,  100,  100,    0,   10, 3000,
     2500,   10, 2100,   30,   40,   50,
       -7,   60, 2200, 2200,   70,   -1,
     2000,    1,   80,   90,  100, 9000 };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [9:0] rowCount = '0;
  logic [6:0] colCount = '0;
  logic inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic signed [15:0] inData = '0;
  logic outValid, outSof, outEof;
  logic [7:0] outMap;

  int nChecks = 0, nFails = 0;
  int cyc = 0;
  int rows, cols, expN = 0, outIdx = 0;
  int firstOutCyc = -1, lastOutCyc = -1;
  int img [1024];
  int expMap [1024];
  int acceptCyc [1024];

  corner_peak_filter i_corner_peak_filter (
    .clk(clk), .rst(rst), .rowCount(rowCount), .colCount(colCount),
    .inValid(inValid), .inSof(inSof), .inEof(inEof), .inData(inData),
    .outValid(outValid), .outSof(outSof), .outEof(outEof), .outMap(outMap));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pix(input int r, input int c);
    if (r < 0 || r >= rows || c < 0 || c >= cols) return 0;
    return img[r*cols + c];
  endfunction

  // Reference from the requirements: zero padding, strict suppression, strict threshold.
  task automatic buildExpect();
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < cols; c++) begin
        int v = pix(r, c);
        bit sup = 0;
        for (int dr = -1; dr <= 1; dr++)
          for (int dc = -1; dc <= 1; dc++)
            if ((dr != 0 || dc != 0) && pix(r+dr, c+dc) > v) sup = 1;
        expMap[r*cols + c] = (!sup && v > THR) ? 255 : 0;
      end
    end
  endtask

  task automatic fillPattern(input int seed);
    for (int i = 0; i < rows*cols; i++)
      img[i] = ((i*73 + seed*11) % 61) * 80 - 400;
  endtask

  // Output monitor, sampled away from the rising edge.
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (outIdx >= expN) begin
        check(0, "R3", "unexpected extra result", outIdx, expN);
      end else begin
        check(int'(outMap) == expMap[outIdx], "R4 R5 R6", $sformatf("map[%0d]", outIdx),
              int'(outMap), expMap[outIdx]);
        check(outSof == (outIdx == 0), "R3", $sformatf("start flag at %0d", outIdx),
              int'(outSof), int'(outIdx == 0));
        check(outEof == (outIdx == expN-1), "R3", $sformatf("end flag at %0d", outIdx),
              int'(outEof), int'(outIdx == expN-1));
      end
      if (outIdx == 0) firstOutCyc = cyc;
      lastOutCyc = cyc;
      outIdx++;
    end
  end

  task automatic driveIdle();
    inValid = 0; inSof = 0; inEof = 0; inData = '0;
  endtask

  task automatic sendFrame(input bit gaps, input int upTo);
    int n = rows*cols;
    outIdx = 0; expN = n; firstOutCyc = -1; lastOutCyc = -1;
    buildExpect();
    for (int i = 0; i < upTo; i++) begin
      if (gaps && (i % 3 == 2)) begin   // R9 bubbles
        @(negedge clk); driveIdle();
      end
      @(negedge clk);
      rowCount = 10'(rows); colCount = 7'(cols);
      inValid = 1; inSof = (i == 0); inEof = (i == n-1);
      inData = 16'(img[i]);
      acceptCyc[i] = cyc + 1;
    end
    @(negedge clk); driveIdle();
  endtask

  task automatic waitFrame(input string tag);
    for (int t = 0; t < 5000 && outIdx < expN; t++) @(negedge clk);
    repeat (2*cols + 6) @(negedge clk);
    check(outIdx == expN, "R3", {tag, " result count"}, outIdx, expN);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1: reset state.
    repeat (3) @(negedge clk);
    check(outValid == 0 && outSof == 0 && outEof == 0, "R1", "flags in reset",
          int'(outValid), 0);
    check(outMap == 8'h00, "R1", "map in reset", int'(outMap), 0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check(outValid == 0 && outMap == 8'h00, "R1", "first cycle after reset",
          int'(outValid), 0);

    // Table frame: row wrap (R4), ties (R5), threshold equality (R6).
    rows = RA; cols = CA;
    for (int i = 0; i < RA*CA; i++) img[i] = FRAME_A[i];
    sendFrame(0, RA*CA);
    waitFrame("table frame");
    check(firstOutCyc == acceptCyc[cols+1], "R7", "first result cycle",
          firstOutCyc, acceptCyc[cols+1]);
    check(lastOutCyc == acceptCyc[RA*CA-1] + cols + 1, "R8", "flush end cycle",
          lastOutCyc, acceptCyc[RA*CA-1] + cols + 1);
    check(expMap[6] == 255 && expMap[14] == 255 && expMap[15] == 255 && expMap[18] == 0,
          "R5", "reference covers wrap, tie and equality", expMap[14], 255);

    // R2: samples with no open frame and no start flag are ignored.
    outIdx = 0; expN = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); inValid = 1; inSof = 0; inEof = (i == 5); inData = 16'sd32000;
    end
    @(negedge clk); driveIdle();
    repeat (20) @(negedge clk);
    check(outIdx == 0, "R2", "results from stray samples", outIdx, 0);

    // Full-width frame with bubbles (R9).
    rows = 3; cols = 64; fillPattern(1);
    sendFrame(1, rows*cols);
    waitFrame("full width with gaps R9");

    // Narrowest frame, with input presented during the flush (R8).
    rows = 6; cols = 2; fillPattern(2);
    sendFrame(0, rows*cols);
    for (int i = 0; i < cols-1; i++) begin
      @(negedge clk); inValid = 1; inSof = 1; inEof = 0; inData = 16'sd30000;
    end
    @(negedge clk); driveIdle();
    waitFrame("flush input ignored R8");

    // R1: reset in the middle of a frame, then a clean frame.
    rows = 5; cols = 8; fillPattern(3);
    sendFrame(0, 20);
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    check(outValid == 0 && outMap == 8'h00, "R1", "outputs during mid-frame reset",
          int'(outValid), 0);
    expN = 0; outIdx = 0;
    @(negedge clk); rst = 0;
    repeat (2*cols + 4) @(negedge clk);
    check(outIdx == 0, "R1", "results after mid-frame reset", outIdx, 0);
    sendFrame(0, rows*cols);
    waitFrame("after reset");
    check(firstOutCyc == acceptCyc[cols+1], "R7", "latency after reset",
          firstOutCyc, acceptCyc[cols+1]);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule